// File: doc/BRIEF.md
# Programmable Dot-Clock Display Timing Generator

This block paces a parallel RGB panel. It produces horizontal sync, vertical sync, a data-enable strobe, a pixel-request strobe for the pixel fetch path, and a one-cycle frame-start pulse that the buffer-swap logic can use. One tick of `clk` is one dot clock. The horizontal position counts dot clocks. The vertical position counts lines and advances once at the end of each line.

All geometry comes from configuration inputs, which normally sit in a register bank:
- Line length and frame length are totals that include sync, both porches and the active region.
- The wait counts, measured from the start of the sync pulse, mark where active data begins.
- Separate valid counts give the active width in pixels and the active height in lines.

Each of the three panel pins has its own polarity input. A sync gate decides whether the sync pins toggle. A data-enable presence bit decides whether the data-enable pin is driven at all. Software changes the geometry only while the run input is low.

Top module: `dotTimingGen`

## Requirements
- R1: While `rstN` is low, every output is at its inactive level: `pixReq` and `frameStart` read 0, and each panel pin reads the inverse of its polarity input.
- R2: While running, a line lasts `hPeriod` clocks. Horizontal sync is active during horizontal positions 0 to `hsWidth`-1 of every line.
- R3: A frame lasts `frameLines` lines. Vertical sync is active for whole lines 0 to `vsWidth`-1, so its width is counted in lines rather than clocks.
- R4: `pixReq` is 1 only when the horizontal position lies in [`hWait`, `hWait`+`hValid`) and the line number lies in [`vWait`, `vWait`+`vValid`).
- R5: A panel pin follows its raw active state when its polarity input is 1 and the inverse when it is 0. A polarity change takes effect at once, with no clock delay.
- R6: When `syncOn` is 0 at a clock edge, both sync pins are at their inactive level during the following cycle.
- R7: Data-enable is active exactly when `pixReq` is 1 and `dePresent` was 1 at the same edge. Otherwise data-enable is inactive.
- R8: `frameStart` is high for one clock at horizontal position 0 of line 0, which is the first clock of vertical sync.
- R9: While `runEn` is 0, both positions are held at 0 and all strobes are inactive. After `runEn` rises, the first clock is position 0 of line 0 and raises `frameStart`.
- R10: Every output is registered. Each output reflects the positions and the control inputs as they were one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run; 0 holds the positions at zero |
| syncOn | input | 1 | Lets the sync pins toggle |
| dePresent | input | 1 | Lets the data-enable pin be driven |
| hsPolHigh | input | 1 | 1 = horizontal sync active high |
| vsPolHigh | input | 1 | 1 = vertical sync active high |
| dePolHigh | input | 1 | 1 = data-enable active high |
| hPeriod | input | H_W | Line length in clocks |
| hsWidth | input | H_W | Horizontal sync width in clocks |
| hWait | input | H_W | Horizontal sync width plus left porch |
| hValid | input | H_W | Active pixels per line |
| frameLines | input | V_W | Frame length in lines |
| vsWidth | input | V_W | Vertical sync width in lines |
| vWait | input | V_W | Vertical sync width plus top porch |
| vValid | input | V_W | Active lines per frame |
| hsyncOut | output | 1 | Horizontal sync pin |
| vsyncOut | output | 1 | Vertical sync pin |
| deOut | output | 1 | Data-enable pin |
| pixReq | output | 1 | Active-high pixel request |
| frameStart | output | 1 | One-clock frame-start pulse |

## Verification
The assertions assume three things about the inputs:
- The geometry inputs stay constant while `runEn` is high.
- A line is at least two clocks long.
- The windows nest, with `hsWidth` ≤ `hWait` and `hWait`+`hValid` ≤ `hPeriod`, and likewise vertically.

The stimulus changes geometry only after `runEn` has been low for several clocks. Every configuration it uses satisfies these orderings. Polarity, sync gating and data-enable presence are toggled freely while the block runs, because nothing in the design relies on them being stable.

// File: rtl/dotTimingPkg.sv
package dotTimingPkg;

  // strobes passed from the position control to the output datapath
  typedef struct packed {
    logic running;   // positions are live this cycle
    logic hsAct;     // inside horizontal sync
    logic vsAct;     // inside vertical sync
    logic hAct;      // inside the horizontal active window
    logic vAct;      // inside the vertical active window
    logic frameTop;  // first clock of the frame
  } timingStrobe_t;

  // index of each panel pin in the polarity stage
  localparam int PIN_HS = 0;
  localparam int PIN_VS = 1;
  localparam int PIN_DE = 2;
  localparam int PIN_COUNT = 3;

endpackage

// File: rtl/dotTimingCtrl.sv
module dotTimingCtrl
  import dotTimingPkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           runEn,
  input  logic [H_W-1:0] hPeriod,
  input  logic [H_W-1:0] hsWidth,
  input  logic [H_W-1:0] hWait,
  input  logic [H_W-1:0] hValid,
  input  logic [V_W-1:0] frameLines,
  input  logic [V_W-1:0] vsWidth,
  input  logic [V_W-1:0] vWait,
  input  logic [V_W-1:0] vValid,
  output timingStrobe_t  strobe
);

  // one extra bit so sums and +1 comparisons cannot wrap
  localparam int HX = H_W + 1;
  localparam int VX = V_W + 1;

  logic [H_W-1:0] hCnt;
  logic [V_W-1:0] vCnt;
  logic           lineEnd;
  logic           frameEnd;
  logic [HX-1:0]  hWinEnd;
  logic [VX-1:0]  vWinEnd;

  assign lineEnd  = ({1'b0, hCnt} + HX'(1)) >= {1'b0, hPeriod};
  assign frameEnd = ({1'b0, vCnt} + VX'(1)) >= {1'b0, frameLines};
  assign hWinEnd  = {1'b0, hWait} + {1'b0, hValid};
  assign vWinEnd  = {1'b0, vWait} + {1'b0, vValid};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!runEn) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= frameEnd ? '0 : vCnt + V_W'(1);
    end else begin
      hCnt <= hCnt + H_W'(1);
    end
  end

  always_comb begin
    strobe.running  = runEn;
    strobe.hsAct    = hCnt < hsWidth;
    strobe.vsAct    = vCnt < vsWidth;
    strobe.hAct     = (hCnt >= hWait) && ({1'b0, hCnt} < hWinEnd);
    strobe.vAct     = (vCnt >= vWait) && ({1'b0, vCnt} < vWinEnd);
    strobe.frameTop = (hCnt == '0) && (vCnt == '0);
  end

endmodule

// File: rtl/dotTimingOut.sv
module dotTimingOut
  import dotTimingPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  timingStrobe_t strobe,
  input  logic          syncOn,
  input  logic          dePresent,
  input  logic          hsPolHigh,
  input  logic          vsPolHigh,
  input  logic          dePolHigh,
  output logic          hsyncOut,
  output logic          vsyncOut,
  output logic          deOut,
  output logic          pixReq,
  output logic          frameStart
);

  logic [PIN_COUNT-1:0] actQ;
  logic [PIN_COUNT-1:0] polHigh;
  logic [PIN_COUNT-1:0] pinLvl;
  logic                 reqQ;
  logic                 topQ;
  logic                 reqNext;

  assign reqNext = strobe.running && strobe.hAct && strobe.vAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actQ <= '0;
      reqQ <= 1'b0;
      topQ <= 1'b0;
    end else begin
      actQ[PIN_HS] <= strobe.running && strobe.hsAct && syncOn;
      actQ[PIN_VS] <= strobe.running && strobe.vsAct && syncOn;
      actQ[PIN_DE] <= reqNext && dePresent;
      reqQ         <= reqNext;
      topQ         <= strobe.running && strobe.frameTop;
    end
  end

  assign polHigh[PIN_HS] = hsPolHigh;
  assign polHigh[PIN_VS] = vsPolHigh;
  assign polHigh[PIN_DE] = dePolHigh;

  // polarity applied after the register so a change shows at once
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pol
    assign pinLvl[i] = polHigh[i] ? actQ[i] : ~actQ[i];
  end

  assign hsyncOut   = pinLvl[PIN_HS];
  assign vsyncOut   = pinLvl[PIN_VS];
  assign deOut      = pinLvl[PIN_DE];
  assign pixReq     = reqQ;
  assign frameStart = topQ;

endmodule

// File: rtl/dotTimingGen.sv
module dotTimingGen
  import dotTimingPkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           runEn,
  input  logic           syncOn,
  input  logic           dePresent,
  input  logic           hsPolHigh,
  input  logic           vsPolHigh,
  input  logic           dePolHigh,
  input  logic [H_W-1:0] hPeriod,
  input  logic [H_W-1:0] hsWidth,
  input  logic [H_W-1:0] hWait,
  input  logic [H_W-1:0] hValid,
  input  logic [V_W-1:0] frameLines,
  input  logic [V_W-1:0] vsWidth,
  input  logic [V_W-1:0] vWait,
  input  logic [V_W-1:0] vValid,
  output logic           hsyncOut,
  output logic           vsyncOut,
  output logic           deOut,
  output logic           pixReq,
  output logic           frameStart
);

  timingStrobe_t strobe;

  dotTimingCtrl #(.H_W(H_W), .V_W(V_W)) ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn),
    .hPeriod(hPeriod), .hsWidth(hsWidth), .hWait(hWait), .hValid(hValid),
    .frameLines(frameLines), .vsWidth(vsWidth), .vWait(vWait), .vValid(vValid),
    .strobe(strobe)
  );

  dotTimingOut dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .syncOn(syncOn), .dePresent(dePresent),
    .hsPolHigh(hsPolHigh), .vsPolHigh(vsPolHigh), .dePolHigh(dePolHigh),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pixReq(pixReq), .frameStart(frameStart)
  );

endmodule

// File: rtl/dotTimingChecker.sv
module dotTimingChecker #(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input logic           clk,
  input logic           rstN,
  input logic           runEn,
  input logic           syncOn,
  input logic           dePresent,
  input logic           hsPolHigh,
  input logic           vsPolHigh,
  input logic           dePolHigh,
  input logic [H_W-1:0] hPeriod,
  input logic [V_W-1:0] vsWidth,
  input logic           hsyncOut,
  input logic           vsyncOut,
  input logic           deOut,
  input logic           pixReq,
  input logic           frameStart
);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!pixReq && !frameStart));

  assert_sync_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    !syncOn |=> ((hsyncOut != hsPolHigh) && (vsyncOut != vsPolHigh)));

  assert_de_within_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    !pixReq |-> (deOut != dePolHigh));

  assert_de_absent_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dePresent |=> (deOut != dePolHigh));

  assert_frame_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && (hPeriod > 1)) |=> !frameStart);

  assert_frame_in_vsync_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && $past(syncOn) && (vsWidth != 0)) |-> (vsyncOut == vsPolHigh));

endmodule

bind dotTimingGen dotTimingChecker #(.H_W(H_W), .V_W(V_W)) chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .syncOn(syncOn), .dePresent(dePresent),
  .hsPolHigh(hsPolHigh), .vsPolHigh(vsPolHigh), .dePolHigh(dePolHigh),
  .hPeriod(hPeriod), .vsWidth(vsWidth),
  .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
  .pixReq(pixReq), .frameStart(frameStart)
);

// File: tb/dotTimingGen_test.sv
`timescale 1ns/1ps
module dotTimingGen_test;

  localparam int H_W = 12;
  localparam int V_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0, syncOn = 1'b1, dePresent = 1'b1;
  logic hsPolHigh = 1'b1, vsPolHigh = 1'b1, dePolHigh = 1'b1;
  logic [H_W-1:0] hPeriod, hsWidth, hWait, hValid;
  logic [V_W-1:0] frameLines, vsWidth, vWait, vValid;
  logic hsyncOut, vsyncOut, deOut, pixReq, frameStart;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dotTimingGen #(.H_W(H_W), .V_W(V_W)) uut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .syncOn(syncOn), .dePresent(dePresent),
    .hsPolHigh(hsPolHigh), .vsPolHigh(vsPolHigh), .dePolHigh(dePolHigh),
    .hPeriod(hPeriod), .hsWidth(hsWidth), .hWait(hWait), .hValid(hValid),
    .frameLines(frameLines), .vsWidth(vsWidth), .vWait(vWait), .vValid(vValid),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .pixReq(pixReq), .frameStart(frameStart)
  );

  // behavioural reference: plain integer positions, raw active states
  int mh = 0, mv = 0;
  bit eHs, eVs, eDe, eReq, eTop;

  always @(posedge clk) begin
    if (!rstN) begin
      mh = 0; mv = 0;
      eHs = 0; eVs = 0; eDe = 0; eReq = 0; eTop = 0;
    end else begin
      eReq = runEn && mh >= int'(hWait) && mh < int'(hWait) + int'(hValid)
                   && mv >= int'(vWait) && mv < int'(vWait) + int'(vValid);
      eDe  = eReq && dePresent;
      eHs  = runEn && syncOn && mh < int'(hsWidth);
      eVs  = runEn && syncOn && mv < int'(vsWidth);
      eTop = runEn && mh == 0 && mv == 0;
      if (!runEn) begin
        mh = 0; mv = 0;
      end else if (mh + 1 >= int'(hPeriod)) begin
        mh = 0;
        mv = (mv + 1 >= int'(frameLines)) ? 0 : mv + 1;
      end else begin
        mh = mh + 1;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic checkInt(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference (R10 registered timing)
  always @(negedge clk) begin
    if (rstN) begin
      check("R2 R5 R6 hsync", hsyncOut, hsPolHigh ? eHs : !eHs);
      check("R3 R5 R6 vsync", vsyncOut, vsPolHigh ? eVs : !eVs);
      check("R4 pixReq", pixReq, eReq);
      check("R7 R5 de", deOut, dePolHigh ? eDe : !eDe);
      check("R8 R9 frameStart", frameStart, eTop);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic setGeom(input int hp, hs, hw, hv, fl, vs, vw, vv);
    hPeriod = H_W'(hp); hsWidth = H_W'(hs); hWait = H_W'(hw); hValid = H_W'(hv);
    frameLines = V_W'(fl); vsWidth = V_W'(vs); vWait = V_W'(vw); vValid = V_W'(vv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nTop, nHs, nVs, nReq;
    setGeom(20, 3, 6, 10, 12, 2, 4, 6);
    repeat (3) step();
    // R1 reset state
    check("R1 hsync", hsyncOut, 1'b0);
    check("R1 vsync", vsyncOut, 1'b0);
    check("R1 de", deOut, 1'b0);
    check("R1 pixReq", pixReq, 1'b0);
    check("R1 frameStart", frameStart, 1'b0);
    rstN = 1'b1;
    step();
    runEn = 1'b1;
    nTop = 0; nHs = 0; nVs = 0; nReq = 0;
    for (int i = 0; i < 720; i++) begin
      @(negedge clk);
      nTop += frameStart; nHs += hsyncOut; nVs += vsyncOut; nReq += pixReq;
    end
    checkInt("R8 frame pulses", nTop, 3);
    checkInt("R2 hsync clocks", nHs, 3 * 12 * 3);
    checkInt("R3 vsync clocks", nVs, 3 * 2 * 20);
    checkInt("R4 request clocks", nReq, 3 * 6 * 10);
    // R5 inverted polarity while running
    step();
    hsPolHigh = 1'b0; vsPolHigh = 1'b0; dePolHigh = 1'b0;
    repeat (240) step();
    // R6 sync gated off
    syncOn = 1'b0;
    repeat (240) step();
    syncOn = 1'b1;
    // R7 data-enable not present
    dePresent = 1'b0;
    repeat (240) step();
    dePresent = 1'b1;
    hsPolHigh = 1'b1;
    // R9 stop mid-frame, then change geometry while idle
    repeat (37) step();
    runEn = 1'b0;
    repeat (4) step();
    check("R9 idle pixReq", pixReq, 1'b0);
    check("R9 idle frameStart", frameStart, 1'b0);
    setGeom(9, 1, 2, 5, 5, 1, 2, 2);
    repeat (3) step();
    runEn = 1'b1;
    nTop = 0;
    for (int i = 0; i < 270; i++) begin
      @(negedge clk);
      nTop += frameStart;
    end
    checkInt("R9 R8 pulses after restart", nTop, 6);
    step();
    vsPolHigh = 1'b1; dePolHigh = 1'b1;
    repeat (100) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule